// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Current-Sink DAC Code Register

This block is the digital control side of a 10-bit current-sink converter. It is a slave on a two-wire serial bus (I2C). The serial clock and data lines are sampled with the system clock and passed through a glitch filter. The block finds START and STOP conditions and decodes a 7-bit device address whose two lowest bits are ignored. It acknowledges each byte it accepts. Two data bytes build a 16-bit word. Once the second byte has arrived, that word updates the converter code and a software power-down flag.

A master can read the 16-bit word back in the same bit order it was written. After a complete two-byte read, the stored word returns to zero. A dedicated power-down input overrides the software flag without waiting for a clock. After reset the converter code is zero, and it stays zero until a complete write lands. The data line is open-drain: the block only ever pulls it low, through an enable output.

Top module: `dcr_i2c_dac`

## Requirements
- R1: After reset, `dac_code` is 0, `sda_oe` is 0 and `pd_out` equals `pd_pin`.
- R2: An address byte of 0x18 to 0x1F (7-bit address 00011xx, bit 0 = read when 1) is acknowledged with SDA pulled low during the ninth clock.
- R3: Any other address gets no acknowledge. The block keeps SDA released for the rest of that transfer, ignores all following bytes, and leaves the converter unchanged until the next START.
- R4: A write takes two data bytes, high byte first and MSB first, and each data byte is acknowledged, the second one included.
- R5: In the 16-bit word, bit 15 is the software power-down (1 = off) and bits 13..4 are the 10-bit code. Bit 14 and bits 3..0 have no effect on the outputs.
- R6: The converter code and the software power-down flag change only when the second data byte of a write completes. A STOP or repeated START after the first byte leaves them unchanged.
- R7: A read (address bit 0 = 1) returns the stored 16-bit word as two bytes, high byte first and MSB first.
- R8: After a read of both bytes, the stored word is zero, so the next read returns 0x00, 0x00. A read does not change the converter outputs.
- R9: While `pd_pin` is 1, `pd_out` is 1 without waiting for a clock edge, whatever the software flag holds.
- R10: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks is ignored. A spike in the middle of a bit neither ends the transfer nor corrupts the data.
- R11: When the master does not acknowledge the first read byte, the block releases SDA and drives nothing more until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain) |
| pd_pin | input | 1 | Hardware power-down request, active high |
| dac_code | output | 10 | Current converter code |
| pd_out | output | 1 | Power-down enable to the converter |

## Verification
The hardest condition to create is a spike inside a bit. A short inverted pulse on SDA while SCL is high looks to an unfiltered receiver like a START or a STOP, so it would abort the transfer. The bench sends a whole data byte in which every bit carries a spike of three system clocks in the middle of its high phase. This produces both false-START and false-STOP shapes. The bench then checks that the acknowledges and the final code are the same as for a clean write. A second hard case is the gap after the first data byte: the bench ends the transfer there with a STOP and with a repeated START, and checks that the code has not moved.

// File: rtl/dcr_pkg.sv
// Shared constants and types for the DAC code register slave.
// Assumes a fixed 16-bit command word carried as two bytes.
package dcr_pkg;
    localparam int WORD_W   = 16;
    localparam int CODE_W   = 10;
    localparam int CODE_LSB = 4;
    localparam int SPD_BIT  = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WR,
        ST_RD,
        ST_MACK,
        ST_SKIP
    } bus_st_t;
endpackage

// File: rtl/dcr_line_filter.sv
// Synchronises one bus line and passes a new level only after it has been
// stable for FILT_CYC system clocks. Assumes the bus is far slower than clk.
module dcr_line_filter #(
    parameter int FILT_CYC = 5,
    parameter bit IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Two-flop synchroniser followed by a stability counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {2{IDLE_VAL}};
            line_o <= IDLE_VAL;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] != line_o) begin
                if (cnt_q == CW'(FILT_CYC - 1)) begin
                    line_o <= sync_q[1];
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    AST_FILT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> ($past(sync_q[1]) == line_o)); // R10
endmodule

// File: rtl/dcr_bus_fsm.sv
// Two-wire slave protocol engine: START/STOP detection, address match with
// don't-care low bits, byte shifting, acknowledge and read-back driving.
// Assumes filtered, clk-synchronous SCL/SDA; no clock stretching.
module dcr_bus_fsm
    import dcr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR     = 7'h0C,
    parameter int         ADDR_DC_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [WORD_W-1:0] rd_word,
    output logic              sda_oe,
    output logic              wr_vld,
    output logic              wr_idx,
    output logic [7:0]        wr_byte,
    output logic              commit,
    output logic              rd_done
);
    localparam logic [6:0] AMASK = 7'h7F << ADDR_DC_BITS;

    bus_st_t    st_q;
    logic [3:0] cnt_q;
    logic [7:0] sh_q;
    logic [7:0] tx_q;
    logic       rw_q, addr_ph_q, byte_q, nack_q;
    logic       scl_p, sda_p;
    logic       scl_rise, scl_fall, start_det, stop_det, addr_hit;
    logic [2:0] bidx;

    // Bus events derived from the previous filtered levels.
    always_comb begin
        scl_rise  = scl_f & ~scl_p;
        scl_fall  = ~scl_f & scl_p;
        start_det = scl_f & scl_p & sda_p & ~sda_f;
        stop_det  = scl_f & scl_p & ~sda_p & sda_f;
        addr_hit  = ((sh_q[7:1] ^ DEV_ADDR) & AMASK) == 7'h00;
        bidx      = 3'(4'd7 - cnt_q);
    end

    // Protocol state, shift registers and the open-drain enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            sh_q      <= '0;
            tx_q      <= '0;
            rw_q      <= 1'b0;
            addr_ph_q <= 1'b0;
            byte_q    <= 1'b0;
            nack_q    <= 1'b1;
            scl_p     <= 1'b1;
            sda_p     <= 1'b1;
            sda_oe    <= 1'b0;
            wr_vld    <= 1'b0;
            wr_idx    <= 1'b0;
            wr_byte   <= '0;
            commit    <= 1'b0;
            rd_done   <= 1'b0;
        end else begin
            scl_p   <= scl_f;
            sda_p   <= sda_f;
            wr_vld  <= 1'b0;
            commit  <= 1'b0;
            rd_done <= 1'b0;
            if (start_det) begin
                st_q      <= ST_ADDR;
                cnt_q     <= '0;
                sda_oe    <= 1'b0;
                byte_q    <= 1'b0;
                addr_ph_q <= 1'b1;
            end else if (stop_det) begin
                st_q   <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[6:0], sda_f};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (scl_fall && cnt_q == 4'd8) begin
                            cnt_q <= '0;
                            if (st_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    rw_q      <= sh_q[0];
                                    sda_oe    <= 1'b1;
                                    addr_ph_q <= 1'b1;
                                    st_q      <= ST_ACK;
                                end else begin
                                    st_q <= ST_IDLE;
                                end
                            end else begin
                                wr_vld    <= 1'b1;
                                wr_idx    <= byte_q;
                                wr_byte   <= sh_q;
                                commit    <= byte_q;
                                sda_oe    <= 1'b1;
                                addr_ph_q <= 1'b0;
                                st_q      <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_oe    <= 1'b0;
                            cnt_q     <= '0;
                            addr_ph_q <= 1'b0;
                            if (addr_ph_q && rw_q) begin
                                st_q   <= ST_RD;
                                tx_q   <= rd_word[15:8];
                                sda_oe <= ~rd_word[15];
                                byte_q <= 1'b0;
                            end else if (addr_ph_q) begin
                                st_q   <= ST_WR;
                                byte_q <= 1'b0;
                            end else if (!byte_q) begin
                                st_q   <= ST_WR;
                                byte_q <= 1'b1;
                            end else begin
                                st_q <= ST_SKIP;
                            end
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            cnt_q <= cnt_q + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt_q == 4'd8) begin
                                sda_oe <= 1'b0;
                                st_q   <= ST_MACK;
                            end else begin
                                sda_oe <= ~tx_q[bidx];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_f;
                        end else if (scl_fall) begin
                            if (!nack_q && !byte_q) begin
                                byte_q <= 1'b1;
                                tx_q   <= rd_word[7:0];
                                sda_oe <= ~rd_word[7];
                                cnt_q  <= '0;
                                st_q   <= ST_RD;
                            end else begin
                                rd_done <= byte_q;
                                st_q    <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st_q == ST_ADDR && !sda_oe)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE || st_q == ST_SKIP) |-> !sda_oe); // R3
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!$past(scl_f) || $past(start_det) || $past(stop_det))); // R4
endmodule

// File: rtl/dcr_i2c_dac.sv
// Top of the DAC code register slave: filters the bus lines, runs the
// protocol engine, holds the 16-bit input word and the DAC register, and
// merges the hardware power-down pin. Assumes SDA is open-drain outside.
module dcr_i2c_dac
    import dcr_pkg::*;
#(
    parameter int         FILT_CYC     = 5,
    parameter logic [6:0] DEV_ADDR     = 7'h0C,
    parameter int         ADDR_DC_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              pd_pin,
    output logic [CODE_W-1:0] dac_code,
    output logic              pd_out
);
    logic [1:0]        raw_lines, flt_lines;
    logic [WORD_W-1:0] in_word_q;
    logic [WORD_W-1:0] new_word;
    logic              soft_pd_q;
    logic              wr_vld, wr_idx, commit, rd_done;
    logic [7:0]        wr_byte;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        dcr_line_filter #(.FILT_CYC(FILT_CYC), .IDLE_VAL(1'b1)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (flt_lines[g])
        );
    end

    dcr_bus_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_DC_BITS(ADDR_DC_BITS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (flt_lines[1]),
        .sda_f   (flt_lines[0]),
        .rd_word (in_word_q),
        .sda_oe  (sda_oe),
        .wr_vld  (wr_vld),
        .wr_idx  (wr_idx),
        .wr_byte (wr_byte),
        .commit  (commit),
        .rd_done (rd_done)
    );

    // Word as it stands once the low byte has arrived.
    always_comb new_word = {in_word_q[15:8], wr_byte};

    // Input word: loaded byte by byte, cleared after a full read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_word_q <= '0;
        end else if (wr_vld) begin
            if (wr_idx) in_word_q[7:0]  <= wr_byte;
            else        in_word_q[15:8] <= wr_byte;
        end else if (rd_done) begin
            in_word_q <= '0;
        end
    end

    // DAC register: updated only when the second byte completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code  <= '0;
            soft_pd_q <= 1'b0;
        end else if (commit) begin
            dac_code  <= new_word[CODE_LSB +: CODE_W];
            soft_pd_q <= new_word[SPD_BIT];
        end
    end

    // Hardware pin forces power-down without a clock.
    always_comb pd_out = soft_pd_q | pd_pin;

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(dac_code)); // R6
    AST_PD_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        pd_pin |-> pd_out); // R9
endmodule

// File: tb/sim_dcr_i2c_dac.sv
module sim_dcr_i2c_dac;
    localparam int Q = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pd_pin = 1'b0;
    logic       sda_oe;
    logic       sda_line;
    logic [9:0] dac_code;
    logic       pd_out;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    dcr_i2c_dac u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .pd_pin(pd_pin), .dac_code(dac_code), .pd_out(pd_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; wq(Q);
        sda_m = 0; wq(Q);
        scl_m = 0; wq(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1; wq(Q);
        scl_m = 1; wq(Q);
        sda_m = 0; wq(Q);
        scl_m = 0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; wq(Q);
        scl_m = 1; wq(Q);
        sda_m = 1; wq(2 * Q);
    endtask

    task automatic clk_bit(input logic b, input bit glitch, output logic s);
        sda_m = b; wq(Q);
        scl_m = 1; wq(Q / 2);
        if (glitch) begin
            sda_m = ~b; wq(3);
            sda_m = b;
        end
        wq(Q - Q / 2);
        s = sda_line; wq(Q);
        scl_m = 0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, input bit glitch, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], glitch, s);
        clk_bit(1'b1, 1'b0, s);
        ack = !s;
    endtask

    task automatic recv_byte(input bit m_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, 1'b0, s);
            d[i] = s;
        end
        clk_bit(!m_ack, 1'b0, s);
    endtask

    task automatic dac_write(input logic [7:0] a, input logic [15:0] w, output bit [2:0] acks);
        bit k;
        bus_start();
        send_byte(a, 1'b0, k); acks[2] = k;
        send_byte(w[15:8], 1'b0, k); acks[1] = k;
        send_byte(w[7:0], 1'b0, k); acks[0] = k;
        bus_stop();
    endtask

    task automatic dac_read(input logic [7:0] a, output logic [15:0] w, output bit ack);
        logic [7:0] h, l;
        bus_start();
        send_byte(a, 1'b0, ack);
        recv_byte(1'b1, h);
        recv_byte(1'b0, l);
        bus_stop();
        w = {h, l};
    endtask

    task automatic t_reset();
        chk("R1 code", dac_code, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 pd_out", pd_out, 0);
    endtask

    task automatic t_basic_write();
        bit [2:0] a;
        dac_write(8'h18, 16'h2A50, a);
        chk("R2 R4 acks 0x18", a, 3'b111);
        chk("R5 code", dac_code, 10'h2A5);
        chk("R5 pd", pd_out, 0);
        dac_write(8'h1E, 16'hFFFF, a);
        chk("R2 acks 0x1E", a, 3'b111);
        chk("R5 full code", dac_code, 10'h3FF);
        chk("R5 soft pd set", pd_out, 1);
        dac_write(8'h1A, 16'h400F, a);
        chk("R2 acks 0x1A", a, 3'b111);
        chk("R5 unused bits ignored code", dac_code, 0);
        chk("R5 unused bits ignored pd", pd_out, 0);
    endtask

    task automatic t_bad_addr();
        bit [2:0] a;
        dac_write(8'h18, 16'h1230, a);
        dac_write(8'h30, 16'h7FF0, a);
        chk("R3 no ack 0x30", a, 3'b000);
        chk("R3 code kept", dac_code, 10'h123);
        dac_write(8'h10, 16'h5550, a);
        chk("R3 no ack 0x10", a, 3'b000);
        chk("R3 code kept 0x10", dac_code, 10'h123);
    endtask

    task automatic t_abort();
        bit k;
        bus_start();
        send_byte(8'h18, 1'b0, k);
        send_byte(8'h3C, 1'b0, k);
        chk("R4 first byte ack", k, 1);
        chk("R6 no update after one byte", dac_code, 10'h123);
        bus_stop();
        chk("R6 stop abort", dac_code, 10'h123);
        bus_start();
        send_byte(8'h1C, 1'b0, k);
        send_byte(8'h11, 1'b0, k);
        bus_rstart();
        send_byte(8'h18, 1'b0, k);
        chk("R6 readdress after repeated start", k, 1);
        chk("R6 rstart abort", dac_code, 10'h123);
        send_byte(8'h0A, 1'b0, k);
        send_byte(8'hB0, 1'b0, k);
        chk("R4 second byte ack", k, 1);
        bus_stop();
        chk("R6 write after rstart", dac_code, 10'h0AB);
    endtask

    task automatic t_readback();
        bit [2:0] a;
        bit k;
        logic [15:0] w;
        dac_write(8'h18, 16'h1234, a);
        dac_read(8'h19, w, k);
        chk("R7 read ack", k, 1);
        chk("R7 read word", w, 16'h1234);
        chk("R8 code kept after read", dac_code, 10'h123);
        dac_read(8'h1F, w, k);
        chk("R8 cleared word", w, 16'h0000);
        chk("R8 code still kept", dac_code, 10'h123);
    endtask

    task automatic t_nack();
        bit [2:0] a;
        bit k;
        logic [7:0] h, l;
        dac_write(8'h18, 16'hABCD, a);
        bus_start();
        send_byte(8'h19, 1'b0, k);
        recv_byte(1'b0, h);
        chk("R11 first byte", h, 8'hAB);
        recv_byte(1'b0, l);
        chk("R11 released after nack", l, 8'hFF);
        bus_stop();
    endtask

    task automatic t_pd_pin();
        bit [2:0] a;
        dac_write(8'h18, 16'h0100, a);
        wq(2);
        #1 pd_pin = 1'b1;
        #1 chk("R9 async force", pd_out, 1);
        wq(3);
        chk("R9 held", pd_out, 1);
        pd_pin = 1'b0;
        #1 chk("R9 release", pd_out, 0);
        chk("R9 code unaffected", dac_code, 10'h010);
    endtask

    task automatic t_glitch();
        bit k1, k2, k3;
        bus_start();
        send_byte(8'h18, 1'b0, k1);
        send_byte(8'h96, 1'b1, k2);
        send_byte(8'h70, 1'b1, k3);
        bus_stop();
        chk("R10 acks with spikes", {k1, k2, k3}, 3'b111);
        chk("R10 code with spikes", dac_code, 10'h167);
        chk("R10 pd with spikes", pd_out, 1);
    endtask

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(3);
        t_reset();
        t_basic_write();
        t_bad_addr();
        t_abort();
        t_readback();
        t_nack();
        t_pd_pin();
        t_glitch();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule